// File: doc/BRIEF.md
# Power Mode Control and Status Register

This block holds the byte-wide power control register and the power status register of a small microcontroller core. The core's special-function-register bus writes and reads both bytes through one data path: a select input picks the status byte or the control byte. The control byte drives the requests for the low-power modes (idle and power-down). It also holds the on/off and boost controls of an on-chip DC-DC converter, the clock and supply enables of a battery monitor, a general-purpose flag, and a lock bit that stops software from requesting a low-power mode.

Hardware takes part in both registers. An enabled interrupt arriving as a wake event clears the mode bits, and so does a reset event. Power-down takes precedence over idle. A reset event records its cause in the status byte as a single sticky flag, which software clears by writing zero. The top bit of the status byte shows the USB supply-detect input as it is. The converter, the monitor and the clock gates are outside this block; only their control levels leave it.

Top module: `pwr_mode_regs`

## Requirements
- R1: Control byte bit map (bit 7 to bit 0): monitor clock enable, monitor supply enable, boost disable, general flag, converter enable, mode lock, power-down, idle. `rst_n` low sets it to 0x30. With `bus_sel_stat` = 0, `bus_rdata` shows the control byte.
- R2: While the lock bit (bit 2) holds 1 before a write, the write leaves bits 1 and 0 unchanged. Bits 7 to 2 still take the written value at the same edge.
- R3: While the lock bit holds 0 before a write, the written bits 1 and 0 are stored. This applies even when the same write sets the lock.
- R4: `wake_irq` high at an edge clears bits 1 and 0. This beats a write in the same cycle, whose other bits are still stored.
- R5: `idle_req` and `pdown_req` are low in any cycle in which `wake_irq` is high, before the clearing edge.
- R6: When bits 1 and 0 are both 1, `pdown_req` is 1 and `idle_req` is 0.
- R7: `rst_evt` high at an edge returns the control byte to 0x30, overriding any write or wake in that cycle.
- R8: A reset event records its cause in status bits 2:0 and clears the other two flags. `rst_src` 0 (watchdog) sets bit 2, 1 (external pin) sets bit 1, 2 (power fail) sets bit 0, and 3 sets none. `rst_n` clears all flags.
- R9: Writing the status byte (`bus_sel_stat` = 1) clears each cause flag written with 0. A written 1 has no effect. Status bits 6 to 3 always read 0.
- R10: Status bit 7 equals `usb_5v_det` combinationally.
- R11: `bmon_clk_en` = bit 7, `bmon_pwr_en` = bit 6, `boost_en` = NOT bit 5.
- R12: `conv_en` = bit 3 OR `conv_pwr_pin`. `shutdown_req` = NOT bit 3 AND NOT `conv_pwr_pin` AND NOT `ext_supply`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_wr | input | 1 | Write strobe for the selected byte |
| bus_sel_stat | input | 1 | 1 selects the status byte, 0 the control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected byte |
| wake_irq | input | 1 | Enabled interrupt pending (wake event) |
| rst_evt | input | 1 | One-cycle reset event pulse |
| rst_src | input | 2 | Cause code of the reset event |
| usb_5v_det | input | 1 | USB 5 V supply detected |
| conv_pwr_pin | input | 1 | External converter-power pin level |
| ext_supply | input | 1 | External supply present |
| idle_req | output | 1 | Idle mode request |
| pdown_req | output | 1 | Power-down mode request |
| bmon_clk_en | output | 1 | Battery monitor clock enable |
| bmon_pwr_en | output | 1 | Battery monitor supply enable |
| boost_en | output | 1 | Converter high-power boost enable |
| conv_en | output | 1 | Converter enable |
| shutdown_req | output | 1 | Request to shut the device off |

## Verification
The assertions assume that `wake_irq`, `rst_evt` and `rst_src` are synchronous to `clk` and stable around the edge. They also assume a reset event lasts a single cycle with a defined cause code. The bench drives every input at the falling edge and pulses `rst_evt` for exactly one cycle, each time with an explicit code. It holds `bus_wr` low except in write cycles, so the lock and sticky-flag properties see only intended writes.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int BYTE_W  = 8;
  localparam int CAUSE_N = 3;

  localparam int B_BMCLK = 7;
  localparam int B_BMPWR = 6;
  localparam int B_BOOST = 5;
  localparam int B_GFLAG = 4;
  localparam int B_CONV  = 3;
  localparam int B_LOCK  = 2;
  localparam int B_PDN   = 1;
  localparam int B_IDLE  = 0;

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h30;

  typedef enum logic [1:0] {
    SRC_WDT  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_PF   = 2'd2,
    SRC_NONE = 2'd3
  } rst_src_e;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_mode_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter logic [DW-1:0] RST_VAL = CTRL_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          wake_irq,
  input  logic          rst_evt,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] ctrl_d;
  logic          ctrl_en;
  logic          lock_q;

  assign lock_q = ctrl_q[B_LOCK];

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (rst_evt) begin
      ctrl_d  = RST_VAL;
      ctrl_en = 1'b1;
    end else begin
      if (wr_en) begin
        ctrl_d  = wdata;
        ctrl_en = 1'b1;
        if (lock_q) begin
          ctrl_d[B_PDN]  = ctrl_q[B_PDN];
          ctrl_d[B_IDLE] = ctrl_q[B_IDLE];
        end
      end
      if (wake_irq) begin
        ctrl_d[B_PDN]  = 1'b0;
        ctrl_d[B_IDLE] = 1'b0;
        ctrl_en        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= RST_VAL;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && !wake_irq && !rst_evt) |=>
      (ctrl_q[B_PDN:B_IDLE] == $past(ctrl_q[B_PDN:B_IDLE])));

  p_wake_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !rst_evt) |=> (ctrl_q[B_PDN:B_IDLE] == 2'b00));

  p_evt_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (ctrl_q == RST_VAL));
endmodule

// File: rtl/pwr_stat_reg.sv
module pwr_stat_reg
  import pwr_mode_pkg::*;
#(
  parameter int NC    = CAUSE_N,
  localparam int SW   = $clog2(NC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NC-1:0] wdata,
  input  logic          rst_evt,
  input  logic [SW-1:0] rst_src,
  output logic [NC-1:0] cause_q
);
  logic [NC-1:0] hit;
  logic [NC-1:0] cause_d;
  logic          cause_en;

  for (genvar i = 0; i < NC; i++) begin : g_hit
    assign hit[i] = (rst_src == SW'(NC - 1 - i));
  end

  always_comb begin
    cause_d  = cause_q;
    cause_en = 1'b0;
    if (rst_evt) begin
      cause_d  = hit;
      cause_en = 1'b1;
    end else if (wr_en) begin
      cause_d  = cause_q & wdata;
      cause_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

  p_single_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cause_q) <= 1);

  p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_evt && !wr_en) |=> $stable(cause_q));

  p_no_set_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_evt && wr_en) |=> ((cause_q & ~$past(cause_q)) == '0));
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_mode_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctrl_q,
  input  logic          wake_irq,
  input  logic          conv_pwr_pin,
  input  logic          ext_supply,
  output logic          idle_req,
  output logic          pdown_req,
  output logic          bmon_clk_en,
  output logic          bmon_pwr_en,
  output logic          boost_en,
  output logic          conv_en,
  output logic          shutdown_req
);
  always_comb begin
    pdown_req    = ctrl_q[B_PDN] & ~wake_irq;
    idle_req     = ctrl_q[B_IDLE] & ~ctrl_q[B_PDN] & ~wake_irq;
    bmon_clk_en  = ctrl_q[B_BMCLK];
    bmon_pwr_en  = ctrl_q[B_BMPWR];
    boost_en     = ~ctrl_q[B_BOOST];
    conv_en      = ctrl_q[B_CONV] | conv_pwr_pin;
    shutdown_req = ~ctrl_q[B_CONV] & ~conv_pwr_pin & ~ext_supply;
  end

  p_pd_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_req && pdown_req));

  p_wake_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (!idle_req && !pdown_req));

  p_conv_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pwr_pin |-> (conv_en && !shutdown_req));
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel_stat,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        wake_irq,
  input  logic        rst_evt,
  input  logic [1:0]  rst_src,
  input  logic        usb_5v_det,
  input  logic        conv_pwr_pin,
  input  logic        ext_supply,
  output logic        idle_req,
  output logic        pdown_req,
  output logic        bmon_clk_en,
  output logic        bmon_pwr_en,
  output logic        boost_en,
  output logic        conv_en,
  output logic        shutdown_req
);
  localparam int PAD_W = BYTE_W - 1 - CAUSE_N;

  logic [BYTE_W-1:0]  ctrl_q;
  logic [CAUSE_N-1:0] cause_q;
  logic [BYTE_W-1:0]  stat_byte;
  logic               wr_ctrl;
  logic               wr_stat;

  assign wr_ctrl = bus_wr & ~bus_sel_stat;
  assign wr_stat = bus_wr &  bus_sel_stat;

  pwr_ctrl_reg #(.DW(BYTE_W), .RST_VAL(CTRL_RST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ctrl),
    .wdata    (bus_wdata),
    .wake_irq (wake_irq),
    .rst_evt  (rst_evt),
    .ctrl_q   (ctrl_q)
  );

  pwr_stat_reg #(.NC(CAUSE_N)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_stat),
    .wdata   (bus_wdata[CAUSE_N-1:0]),
    .rst_evt (rst_evt),
    .rst_src (rst_src),
    .cause_q (cause_q)
  );

  pwr_out_decode #(.DW(BYTE_W)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_q       (ctrl_q),
    .wake_irq     (wake_irq),
    .conv_pwr_pin (conv_pwr_pin),
    .ext_supply   (ext_supply),
    .idle_req     (idle_req),
    .pdown_req    (pdown_req),
    .bmon_clk_en  (bmon_clk_en),
    .bmon_pwr_en  (bmon_pwr_en),
    .boost_en     (boost_en),
    .conv_en      (conv_en),
    .shutdown_req (shutdown_req)
  );

  assign stat_byte = {usb_5v_det, {PAD_W{1'b0}}, cause_q};
  assign bus_rdata = bus_sel_stat ? stat_byte : ctrl_q;

  p_usb_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_stat |-> (bus_rdata[BYTE_W-1] == usb_5v_det));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_stat |-> (bus_rdata[BYTE_W-2:CAUSE_N] == '0));
endmodule

// File: tb/tb_pwr_mode_regs.sv
`timescale 1ns/1ps
module tb_pwr_mode_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_sel_stat;
  logic [7:0] bus_wdata, bus_rdata;
  logic       wake_irq, rst_evt;
  logic [1:0] rst_src;
  logic       usb_5v_det, conv_pwr_pin, ext_supply;
  logic       idle_req, pdown_req, bmon_clk_en, bmon_pwr_en;
  logic       boost_en, conv_en, shutdown_req;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pwr_mode_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_stat(bus_sel_stat),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_irq(wake_irq),
    .rst_evt(rst_evt), .rst_src(rst_src), .usb_5v_det(usb_5v_det),
    .conv_pwr_pin(conv_pwr_pin), .ext_supply(ext_supply),
    .idle_req(idle_req), .pdown_req(pdown_req), .bmon_clk_en(bmon_clk_en),
    .bmon_pwr_en(bmon_pwr_en), .boost_en(boost_en), .conv_en(conv_en),
    .shutdown_req(shutdown_req)
  );

  // {req[3:0], wr, sel_stat, wdata[7:0], wake, evt, src[1:0], exp_rdata[7:0], exp_idle, exp_pdn}
  localparam int NV = 22;
  localparam logic [27:0] VEC [0:NV-1] = '{
    {4'd3,  1'b1,1'b0,8'h31,1'b0,1'b0,2'd0, 8'h31,1'b1,1'b0}, // R3 idle set
    {4'd4,  1'b0,1'b0,8'h00,1'b1,1'b0,2'd0, 8'h30,1'b0,1'b0}, // R4 wake clears
    {4'd6,  1'b1,1'b0,8'h33,1'b0,1'b0,2'd0, 8'h33,1'b0,1'b1}, // R6 both set
    {4'd4,  1'b0,1'b0,8'h00,1'b1,1'b0,2'd0, 8'h30,1'b0,1'b0}, // R4
    {4'd1,  1'b1,1'b0,8'h34,1'b0,1'b0,2'd0, 8'h34,1'b0,1'b0}, // R1 lock on
    {4'd2,  1'b1,1'b0,8'h37,1'b0,1'b0,2'd0, 8'h34,1'b0,1'b0}, // R2 locked
    {4'd2,  1'b1,1'b0,8'hF5,1'b0,1'b0,2'd0, 8'hF4,1'b0,1'b0}, // R2 others update
    {4'd2,  1'b1,1'b0,8'h31,1'b0,1'b0,2'd0, 8'h30,1'b0,1'b0}, // R2 unlock write held
    {4'd3,  1'b1,1'b0,8'h32,1'b0,1'b0,2'd0, 8'h32,1'b0,1'b1}, // R3 pd set
    {4'd7,  1'b0,1'b0,8'h00,1'b0,1'b1,2'd1, 8'h30,1'b0,1'b0}, // R7 event
    {4'd8,  1'b0,1'b1,8'h00,1'b0,1'b0,2'd0, 8'h02,1'b0,1'b0}, // R8 ext cause
    {4'd8,  1'b0,1'b1,8'h00,1'b0,1'b1,2'd0, 8'h04,1'b0,1'b0}, // R8 wdt replaces
    {4'd9,  1'b1,1'b1,8'hFF,1'b0,1'b0,2'd0, 8'h04,1'b0,1'b0}, // R9 write 1 ignored
    {4'd9,  1'b1,1'b1,8'h00,1'b0,1'b0,2'd0, 8'h00,1'b0,1'b0}, // R9 write 0 clears
    {4'd8,  1'b0,1'b1,8'h00,1'b0,1'b1,2'd2, 8'h01,1'b0,1'b0}, // R8 pf cause
    {4'd4,  1'b1,1'b0,8'h71,1'b1,1'b0,2'd0, 8'h70,1'b0,1'b0}, // R4 wake beats write
    {4'd7,  1'b1,1'b0,8'hFF,1'b0,1'b1,2'd3, 8'h30,1'b0,1'b0}, // R7 event beats write
    {4'd8,  1'b0,1'b1,8'h00,1'b0,1'b0,2'd0, 8'h00,1'b0,1'b0}, // R8 code 3 none
    {4'd6,  1'b1,1'b0,8'h33,1'b0,1'b0,2'd0, 8'h33,1'b0,1'b1}, // R6
    {4'd3,  1'b1,1'b0,8'h07,1'b0,1'b0,2'd0, 8'h07,1'b0,1'b1}, // R3 lock+mode together
    {4'd2,  1'b1,1'b0,8'h04,1'b0,1'b0,2'd0, 8'h07,1'b0,1'b1}, // R2 clear blocked
    {4'd4,  1'b0,1'b0,8'h00,1'b1,1'b0,2'd0, 8'h04,1'b0,1'b0}  // R4
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_quiet();
    bus_wr = 1'b0; bus_sel_stat = 1'b0; bus_wdata = 8'h00;
    wake_irq = 1'b0; rst_evt = 1'b0; rst_src = 2'd0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    bus_quiet();
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_quiet();
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_quiet();
    usb_5v_det = 1'b0; conv_pwr_pin = 1'b0; ext_supply = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ctrl", {6'd0, idle_req, pdown_req, bus_rdata}, {6'd0, 2'b00, 8'h30});
    rst_n = 1'b1;
    @(negedge clk);
    bus_sel_stat = 1'b1;
    #2 chk("R8 reset status", {8'd0, bus_rdata}, 16'h0000);
    bus_sel_stat = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr       = VEC[i][23];
      bus_sel_stat = VEC[i][22];
      bus_wdata    = VEC[i][21:14];
      wake_irq     = VEC[i][13];
      rst_evt      = VEC[i][12];
      rst_src      = VEC[i][11:10];
      @(posedge clk);
      #5;
      chk($sformatf("R%0d vector %0d", VEC[i][27:24], i),
          {6'd0, idle_req, pdown_req, bus_rdata},
          {6'd0, VEC[i][1], VEC[i][0], VEC[i][9:2]});
    end
    @(negedge clk);
    bus_quiet();

    // R5: request drops while wake is high, before the clearing edge
    wr_ctrl(8'h00);
    wr_ctrl(8'h01);
    #2 chk("R5 idle before wake", {15'd0, idle_req}, 16'd1);
    @(negedge clk);
    wake_irq = 1'b1;
    #2 chk("R5 idle masked by wake", {14'd0, idle_req, pdown_req}, 16'd0);
    @(negedge clk);
    wake_irq = 1'b0;
    wr_ctrl(8'h02);
    @(negedge clk);
    wake_irq = 1'b1;
    #2 chk("R5 pdown masked by wake", {14'd0, idle_req, pdown_req}, 16'd0);
    @(negedge clk);
    wake_irq = 1'b0;

    // R10 live USB detect
    bus_sel_stat = 1'b1; usb_5v_det = 1'b1;
    #2 chk("R10 usb high", {8'd0, bus_rdata}, 16'h0080);
    usb_5v_det = 1'b0;
    #2 chk("R10 usb low", {8'd0, bus_rdata}, 16'h0000);
    bus_sel_stat = 1'b0;

    // R11 / R12 output decoding
    wr_ctrl(8'hC0);
    #2 chk("R11 monitor and boost", {13'd0, bmon_clk_en, bmon_pwr_en, boost_en}, 16'h0007);
    chk("R12 shutdown no supply", {14'd0, conv_en, shutdown_req}, 16'h0001);
    ext_supply = 1'b1;
    #2 chk("R12 external supply", {14'd0, conv_en, shutdown_req}, 16'h0000);
    ext_supply = 1'b0; conv_pwr_pin = 1'b1;
    #2 chk("R12 pin holds converter", {14'd0, conv_en, shutdown_req}, 16'h0002);
    conv_pwr_pin = 1'b0;
    wr_ctrl(8'h28);
    #2 chk("R11 boost off monitor off", {13'd0, bmon_clk_en, bmon_pwr_en, boost_en}, 16'h0000);
    chk("R12 bit enables converter", {14'd0, conv_en, shutdown_req}, 16'h0002);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule